// File: doc/BRIEF.md
# Legacy Memory and SMM Routing Decoder

This block decides where each memory or I/O cycle from the host side goes. It takes one request per clock. The request carries an address, a cycle kind, the initiator and the processor's system-management flag. One cycle later the block returns a one-hot destination and the address to forward. The possible destinations are system DRAM, the graphics port, the PCI bus, the local configuration registers, or a reject.

The decode covers four areas:
- The legacy video window (A0000h–BFFFFh). It can serve as system-management RAM.
- An optional second system-management window at C0000h–CFFFFh.
- Sixteen 16 KB shadow segments from C0000h to FFFFFh. Read routing and write routing are set separately for each segment.
- The 64 KB I/O space.

A small control register sets up the system-management RAM: enable, open for initialization, lock and second window. Once locked, the register freezes until reset.

Top module: `legacy_route_dec`

## Requirements
- R1: Each request with `req_valid_i` high produces exactly one response one clock later. `rsp_valid_o` is high and exactly one bit of `rsp_target_o` is set. The bit encoding is: bit 0 DRAM, bit 1 graphics port, bit 2 PCI, bit 3 local configuration, bit 4 reject. `req_kind_i` codes are 0 memory read, 1 memory write and 2 I/O. Code 3 is rejected.
- R2: With the SMM enable clear, any memory cycle to A0000h–BFFFFh goes to the video bus and never to DRAM, whatever the initiator. The video bus is the graphics port when `vga_on_gfx_i` is 1 and PCI otherwise.
- R3: With SMM enabled, a CPU memory cycle to A0000h–BFFFFh goes to DRAM when `req_smm_i` is 1 or the open bit is set. Otherwise it goes to the video bus.
- R4: With SMM enabled, a bus-master (`req_cpu_i` = 0) memory cycle to any active SMM window is rejected.
- R5: With SMM enabled and the high-window bit set, C0000h–CFFFFh is SMM space under the rules of R3 and R4. A CPU cycle that is not granted there falls back to shadow routing (R6).
- R6: Addresses C0000h–FFFFFh form 16 segments of 16 KB, with segment n = (addr − C0000h) >> 14. A read goes to DRAM if `shd_rd_en_i[n]` is set. A write goes to DRAM if `shd_wr_en_i[n]` is set. Any other cycle goes to PCI.
- R7: Memory cycles outside A0000h–FFFFFh go to DRAM. The forwarded memory address equals the request address.
- R8: `smram_wdata_i` bit 0 is enable, bit 1 is open, bit 2 is lock and bit 3 is the high window. A write that sets lock also clears open. While locked, writes are ignored until reset.
- R9: CPU I/O cycles to ports 0CF8h–0CFFh (the configuration address and data dwords) are claimed locally.
- R10: All other CPU I/O cycles go to the graphics port when `io_gfx_base_i` ≤ port ≤ `io_gfx_limit_i`, and to PCI otherwise. Bus-master I/O cycles are rejected. No I/O cycle reaches DRAM.
- R11: The I/O port is the low 16 address bits, so addresses just past 0FFFFh wrap to port 0. The forwarded I/O address holds that port with all upper bits zero.
- R12: Reset clears `rsp_valid_o`, `rsp_target_o` and the control register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request present this cycle |
| req_addr_i | input | ADDR_W | Request address |
| req_kind_i | input | 2 | 0 memory read, 1 memory write, 2 I/O |
| req_cpu_i | input | 1 | 1 = CPU initiator, 0 = bus master |
| req_smm_i | input | 1 | CPU is in system-management mode |
| vga_on_gfx_i | input | 1 | Legacy video sits behind the graphics port |
| shd_rd_en_i | input | SEG_N | Per-segment shadow read to DRAM |
| shd_wr_en_i | input | SEG_N | Per-segment shadow write to DRAM |
| io_gfx_base_i | input | IO_W | Lowest I/O port of the graphics window |
| io_gfx_limit_i | input | IO_W | Highest I/O port of the graphics window |
| smram_wr_i | input | 1 | Write strobe for the SMM control register |
| smram_wdata_i | input | 4 | SMM control write data |
| rsp_valid_o | output | 1 | Response valid |
| rsp_target_o | output | 5 | One-hot destination |
| rsp_addr_o | output | ADDR_W | Forwarded address |

## Verification
On every cycle, the assertions check the following:
- the one-cycle response and its one-hot target;
- that bus masters are rejected from the enabled video window;
- that the video window never lands in DRAM while SMM is disabled;
- that I/O never reaches DRAM and always has zeroed upper address bits;
- that the lock bit is sticky, freezes the register and keeps open clear.

Other behaviours only the bench sweeps can show: per-segment read/write independence, the fall-back of the high window to shadow routing, the exact edges of each window, the wrap of ports past 0FFFFh, and the choice between graphics port and PCI.

// File: rtl/lrd_pkg.sv
package lrd_pkg;

    typedef enum logic [1:0] {
        KIND_MRD  = 2'd0,
        KIND_MWR  = 2'd1,
        KIND_IO   = 2'd2,
        KIND_RSVD = 2'd3
    } kind_e;

    localparam int TGT_W     = 5;
    localparam int TGT_DRAM  = 0;
    localparam int TGT_GFX   = 1;
    localparam int TGT_PCI   = 2;
    localparam int TGT_LOCAL = 3;
    localparam int TGT_REJ   = 4;

    typedef logic [TGT_W-1:0] tgt_t;

    localparam tgt_t T_DRAM  = tgt_t'(1) << TGT_DRAM;
    localparam tgt_t T_GFX   = tgt_t'(1) << TGT_GFX;
    localparam tgt_t T_PCI   = tgt_t'(1) << TGT_PCI;
    localparam tgt_t T_LOCAL = tgt_t'(1) << TGT_LOCAL;
    localparam tgt_t T_REJ   = tgt_t'(1) << TGT_REJ;

    typedef struct packed {
        logic hi_win;
        logic locked;
        logic open;
        logic enable;
    } smram_t;

    // Fixed legacy map
    localparam logic [31:0] VID_LO = 32'h000A_0000;
    localparam logic [31:0] VID_HI = 32'h000B_FFFF;
    localparam logic [31:0] HIW_LO = 32'h000C_0000;
    localparam logic [31:0] HIW_HI = 32'h000C_FFFF;

    // Configuration address dword; the data dword follows at +4
    localparam logic [15:0] CFG_PORT = 16'h0CF8;

endpackage

// File: rtl/lrd_smram_ctl.sv
module lrd_smram_ctl
    import lrd_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       wr_i,
    input  logic [3:0] wdata_i,
    output logic       enable_o,
    output logic       open_o,
    output logic       hi_win_o
);

    smram_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_i && !cfg_q.locked) begin
            cfg_d.enable = wdata_i[0];
            cfg_d.open   = wdata_i[1] && !wdata_i[2];
            cfg_d.locked = wdata_i[2];
            cfg_d.hi_win = wdata_i[3];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cfg_q <= '0;
        else         cfg_q <= cfg_d;
    end

    assign enable_o = cfg_q.enable;
    assign open_o   = cfg_q.open;
    assign hi_win_o = cfg_q.hi_win;

    // R8
    lock_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cfg_q.locked |=> (cfg_q.locked && $stable(cfg_q)));

    // R8
    lock_closed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cfg_q.locked |-> !cfg_q.open);

endmodule

// File: rtl/lrd_mem_map.sv
module lrd_mem_map
    import lrd_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int SEG_N     = 16,
    parameter int SEG_SHIFT = 14
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              is_write_i,
    input  logic              is_cpu_i,
    input  logic              in_smm_i,
    input  logic              vga_on_gfx_i,
    input  logic              smm_en_i,
    input  logic              smm_open_i,
    input  logic              smm_hi_i,
    input  logic [SEG_N-1:0]  shd_rd_i,
    input  logic [SEG_N-1:0]  shd_wr_i,
    output tgt_t              tgt_o
);

    localparam int SEG_IDX_W = (SEG_N > 1) ? $clog2(SEG_N) : 1;
    localparam logic [ADDR_W-1:0] A_VID_LO = ADDR_W'(VID_LO);
    localparam logic [ADDR_W-1:0] A_VID_HI = ADDR_W'(VID_HI);
    localparam logic [ADDR_W-1:0] A_HIW_LO = ADDR_W'(HIW_LO);
    localparam logic [ADDR_W-1:0] A_HIW_HI = ADDR_W'(HIW_HI);
    localparam logic [ADDR_W-1:0] SHD_SPAN = ADDR_W'(SEG_N) << SEG_SHIFT;

    logic                 in_vid, in_hiw, in_shd, smm_space, smm_grant, shd_hit;
    logic [SEG_IDX_W-1:0] seg;
    tgt_t                 video_tgt, shd_tgt;

    always_comb begin
        in_vid    = (addr_i >= A_VID_LO) && (addr_i <= A_VID_HI);
        in_hiw    = (addr_i >= A_HIW_LO) && (addr_i <= A_HIW_HI);
        in_shd    = (addr_i >= A_HIW_LO) && ((addr_i - A_HIW_LO) < SHD_SPAN);
        seg       = SEG_IDX_W'((addr_i - A_HIW_LO) >> SEG_SHIFT);
        shd_hit   = is_write_i ? shd_wr_i[seg] : shd_rd_i[seg];
        shd_tgt   = shd_hit ? T_DRAM : T_PCI;
        video_tgt = vga_on_gfx_i ? T_GFX : T_PCI;
        smm_space = smm_en_i && (in_vid || (in_hiw && smm_hi_i));
        smm_grant = is_cpu_i && (in_smm_i || smm_open_i);

        if (smm_space) begin
            if (!is_cpu_i)      tgt_o = T_REJ;
            else if (smm_grant) tgt_o = T_DRAM;
            else if (in_vid)    tgt_o = video_tgt;
            else                tgt_o = shd_tgt;
        end else if (in_vid) begin
            tgt_o = video_tgt;
        end else if (in_shd) begin
            tgt_o = shd_tgt;
        end else begin
            tgt_o = T_DRAM;
        end
    end

endmodule

// File: rtl/lrd_io_map.sv
module lrd_io_map
    import lrd_pkg::*;
#(
    parameter int IO_W = 16
) (
    input  logic [IO_W-1:0] port_i,
    input  logic            is_cpu_i,
    input  logic [IO_W-1:0] base_i,
    input  logic [IO_W-1:0] limit_i,
    output tgt_t            tgt_o
);

    localparam logic [IO_W-1:0] CFG_DW = IO_W'(CFG_PORT) >> 3;

    logic cfg_hit, win_hit;

    always_comb begin
        cfg_hit = (port_i >> 3) == CFG_DW;
        win_hit = (port_i >= base_i) && (port_i <= limit_i);
        if (!is_cpu_i)    tgt_o = T_REJ;
        else if (cfg_hit) tgt_o = T_LOCAL;
        else if (win_hit) tgt_o = T_GFX;
        else              tgt_o = T_PCI;
    end

endmodule

// File: rtl/legacy_route_dec.sv
module legacy_route_dec
    import lrd_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int IO_W      = 16,
    parameter int SEG_N     = 16,
    parameter int SEG_SHIFT = 14
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              req_valid_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [1:0]        req_kind_i,
    input  logic              req_cpu_i,
    input  logic              req_smm_i,
    input  logic              vga_on_gfx_i,
    input  logic [SEG_N-1:0]  shd_rd_en_i,
    input  logic [SEG_N-1:0]  shd_wr_en_i,
    input  logic [IO_W-1:0]   io_gfx_base_i,
    input  logic [IO_W-1:0]   io_gfx_limit_i,
    input  logic              smram_wr_i,
    input  logic [3:0]        smram_wdata_i,
    output logic              rsp_valid_o,
    output logic [TGT_W-1:0]  rsp_target_o,
    output logic [ADDR_W-1:0] rsp_addr_o
);

    localparam int UP_W = ADDR_W - IO_W;

    typedef struct packed {
        logic              valid;
        tgt_t              tgt;
        logic [ADDR_W-1:0] addr;
    } rsp_t;

    rsp_t  rsp_d, rsp_q;
    logic  smm_en, smm_open, smm_hi;
    tgt_t  mem_tgt, io_tgt;
    kind_e kind;

    lrd_smram_ctl u_smram (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .wr_i     (smram_wr_i),
        .wdata_i  (smram_wdata_i),
        .enable_o (smm_en),
        .open_o   (smm_open),
        .hi_win_o (smm_hi)
    );

    lrd_mem_map #(
        .ADDR_W    (ADDR_W),
        .SEG_N     (SEG_N),
        .SEG_SHIFT (SEG_SHIFT)
    ) u_mem (
        .addr_i       (req_addr_i),
        .is_write_i   (req_kind_i == KIND_MWR),
        .is_cpu_i     (req_cpu_i),
        .in_smm_i     (req_smm_i),
        .vga_on_gfx_i (vga_on_gfx_i),
        .smm_en_i     (smm_en),
        .smm_open_i   (smm_open),
        .smm_hi_i     (smm_hi),
        .shd_rd_i     (shd_rd_en_i),
        .shd_wr_i     (shd_wr_en_i),
        .tgt_o        (mem_tgt)
    );

    lrd_io_map #(
        .IO_W (IO_W)
    ) u_io (
        .port_i   (req_addr_i[IO_W-1:0]),
        .is_cpu_i (req_cpu_i),
        .base_i   (io_gfx_base_i),
        .limit_i  (io_gfx_limit_i),
        .tgt_o    (io_tgt)
    );

    always_comb begin
        kind        = kind_e'(req_kind_i);
        rsp_d       = '0;
        rsp_d.valid = req_valid_i;
        if (req_valid_i) begin
            unique case (kind)
                KIND_MRD, KIND_MWR: begin
                    rsp_d.tgt  = mem_tgt;
                    rsp_d.addr = req_addr_i;
                end
                KIND_IO: begin
                    rsp_d.tgt  = io_tgt;
                    rsp_d.addr = {{UP_W{1'b0}}, req_addr_i[IO_W-1:0]};
                end
                default: begin
                    rsp_d.tgt  = T_REJ;
                    rsp_d.addr = req_addr_i;
                end
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) rsp_q <= '0;
        else         rsp_q <= rsp_d;
    end

    assign rsp_valid_o  = rsp_q.valid;
    assign rsp_target_o = rsp_q.tgt;
    assign rsp_addr_o   = rsp_q.addr;

    // R1
    rsp_follows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_valid_i |=> rsp_valid_o);

    // R1
    tgt_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rsp_valid_o |-> ($countones(rsp_target_o) == 1));

    // R4
    master_smm_rej_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && !req_cpu_i && smm_en && (req_kind_i != 2'd2) && (req_kind_i != 2'd3)
         && (req_addr_i >= ADDR_W'(VID_LO)) && (req_addr_i <= ADDR_W'(VID_HI)))
        |=> (rsp_target_o == T_REJ));

    // R2
    vid_no_dram_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && !smm_en && (req_kind_i != 2'd2) && (req_kind_i != 2'd3)
         && (req_addr_i >= ADDR_W'(VID_LO)) && (req_addr_i <= ADDR_W'(VID_HI)))
        |=> !rsp_target_o[TGT_DRAM]);

    // R10
    io_no_dram_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && (req_kind_i == 2'd2)) |=> !rsp_target_o[TGT_DRAM]);

    // R11
    io_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && (req_kind_i == 2'd2)) |=> (rsp_addr_o[ADDR_W-1:IO_W] == '0));

endmodule

// File: tb/legacy_route_dec_tb_top.sv
module legacy_route_dec_tb_top;
    import lrd_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_kind = '0;
    logic        req_cpu = 1'b0;
    logic        req_smm = 1'b0;
    logic        vga_gfx = 1'b0;
    logic [15:0] shd_rd = '0;
    logic [15:0] shd_wr = '0;
    logic [15:0] io_base = 16'h3000;
    logic [15:0] io_limit = 16'h3FFF;
    logic        sm_wr = 1'b0;
    logic [3:0]  sm_wdata = '0;
    logic        rsp_valid;
    logic [4:0]  rsp_target;
    logic [31:0] rsp_addr;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    legacy_route_dec dut_i (
        .clk_i          (clk),
        .rst_ni         (rst_n),
        .req_valid_i    (req_valid),
        .req_addr_i     (req_addr),
        .req_kind_i     (req_kind),
        .req_cpu_i      (req_cpu),
        .req_smm_i      (req_smm),
        .vga_on_gfx_i   (vga_gfx),
        .shd_rd_en_i    (shd_rd),
        .shd_wr_en_i    (shd_wr),
        .io_gfx_base_i  (io_base),
        .io_gfx_limit_i (io_limit),
        .smram_wr_i     (sm_wr),
        .smram_wdata_i  (sm_wdata),
        .rsp_valid_o    (rsp_valid),
        .rsp_target_o   (rsp_target),
        .rsp_addr_o     (rsp_addr)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s addr=%h kind=%0d cpu=%0b smm=%0b actual=%h expected=%h",
                     tag, req_addr, req_kind, req_cpu, req_smm, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        req_valid = 1'b1;
        @(negedge clk);
        // R12: reset state
        chk("R12 valid", 64'(rsp_valid), 64'd0);
        chk("R12 target", 64'(rsp_target), 64'd0);
        req_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic cfg_write(input logic [3:0] v);
        sm_wr = 1'b1;
        sm_wdata = v;
        @(negedge clk);
        sm_wr = 1'b0;
    endtask

    task automatic issue(input logic [31:0] a, input logic [1:0] k, input logic cpu, input logic smm);
        req_valid = 1'b1;
        req_addr = a;
        req_kind = k;
        req_cpu = cpu;
        req_smm = smm;
        @(negedge clk);
    endtask

    // Expected memory target from R2..R7
    function automatic logic [4:0] exp_mem(input logic [31:0] a, input logic wr, input logic cpu,
                                           input logic smm, input logic en, input logic opn,
                                           input logic hi, input logic vga,
                                           input logic [15:0] rd, input logic [15:0] wv);
        logic       vid;
        logic       hiw;
        logic       shd;
        logic [4:0] vt;
        logic [4:0] st;
        int         seg;
        vid = (a >= 32'hA0000) && (a <= 32'hBFFFF);
        hiw = (a >= 32'hC0000) && (a <= 32'hCFFFF);
        shd = (a >= 32'hC0000) && (a <= 32'hFFFFF);
        vt  = vga ? 5'b00010 : 5'b00100;
        seg = shd ? int'((a - 32'hC0000) / 32'h4000) : 0;
        st  = (wr ? wv[seg] : rd[seg]) ? 5'b00001 : 5'b00100;
        if (en && (vid || (hiw && hi))) begin
            if (!cpu)             return 5'b10000;
            else if (smm || opn)  return 5'b00001;
            else if (vid)         return vt;
            else                  return st;
        end
        if (vid) return vt;
        if (shd) return st;
        return 5'b00001;
    endfunction

    function automatic string mem_tag(input logic [31:0] a, input logic cpu, input logic en, input logic hi);
        if (a >= 32'hA0000 && a <= 32'hBFFFF) return en ? (cpu ? "R3" : "R4") : "R2";
        if (a >= 32'hC0000 && a <= 32'hCFFFF && en && hi) return "R5";
        if (a >= 32'hC0000 && a <= 32'hFFFFF) return "R6";
        return "R7";
    endfunction

    function automatic logic [4:0] exp_io(input logic [31:0] a, input logic cpu);
        logic [15:0] p;
        p = a[15:0];
        if (!cpu) return 5'b10000;
        if (p >= 16'h0CF8 && p <= 16'h0CFF) return 5'b01000;
        if (p >= 16'h3000 && p <= 16'h3FFF) return 5'b00010;
        return 5'b00100;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        do_reset();

        // Memory sweep: every SMM config, two shadow patterns, both edges of each 4 KB page
        for (int c = 0; c < 8; c++) begin
            do_reset();
            cfg_write({c[2], 1'b0, c[1], c[0]});
            for (int pat = 0; pat < 2; pat++) begin
                vga_gfx = pat[0];
                shd_rd  = (pat == 0) ? 16'hA5C3 : 16'h0000;
                shd_wr  = (pat == 0) ? 16'h3C5A : 16'h0000;
                for (int i = 0; i < 196; i++) begin
                    for (int k = 0; k < 2; k++) begin
                        for (int cp = 0; cp < 2; cp++) begin
                            for (int sm = 0; sm < 2; sm++) begin
                                logic [31:0] a;
                                logic [4:0]  e;
                                a = 32'h9F000 + 32'(i / 2) * 32'h1000 + ((i % 2) != 0 ? 32'hFFF : 32'h0);
                                e = exp_mem(a, k[0], cp[0], sm[0], c[0], c[1], c[2], vga_gfx, shd_rd, shd_wr);
                                issue(a, k[1:0], cp[0], sm[0]);
                                chk(mem_tag(a, cp[0], c[0], c[2]), 64'(rsp_target), 64'(e));
                                // R1 and R7: valid and unchanged memory address
                                chk("R1", 64'(rsp_valid), 64'd1);
                                chk("R7 addr", 64'(rsp_addr), 64'(a));
                            end
                        end
                    end
                end
            end
        end

        // I/O sweep: configuration ports, graphics window edges, wrap past 64 KB
        do_reset();
        for (int cp = 0; cp < 2; cp++) begin
            for (int j = 0; j < 40; j++) begin
                logic [31:0] a;
                string       t;
                if (j < 24)      a = 32'h0CF0 + 32'(j);
                else if (j < 28) a = (j == 24) ? 32'h2FFF : (j == 25) ? 32'h3000 : (j == 26) ? 32'h3FFF : 32'h4000;
                else             a = 32'hFFFA + 32'(j - 28);
                t = !cp[0] ? "R10" : (a[15:0] >= 16'h0CF8 && a[15:0] <= 16'h0CFF) ? "R9" : "R10";
                issue(a, 2'd2, cp[0], 1'b0);
                chk(t, 64'(rsp_target), 64'(exp_io(a, cp[0])));
                chk("R11 addr", 64'(rsp_addr), 64'({16'h0, a[15:0]}));
            end
        end
        // R1: reserved kind code rejected
        issue(32'h0001_0000, 2'd3, 1'b1, 1'b0);
        chk("R1 kind3", 64'(rsp_target), 64'h10);

        // R8: lock clears open and freezes the register
        do_reset();
        vga_gfx = 1'b1;
        cfg_write(4'b0111);
        issue(32'hA8000, 2'd0, 1'b1, 1'b0);
        chk("R8 open cleared", 64'(rsp_target), 64'h02);
        issue(32'hA8000, 2'd1, 1'b1, 1'b1);
        chk("R8 smm dram", 64'(rsp_target), 64'h01);
        req_valid = 1'b0;
        cfg_write(4'b0010);
        issue(32'hA8000, 2'd0, 1'b1, 1'b0);
        chk("R8 write ignored open", 64'(rsp_target), 64'h02);
        issue(32'hB0000, 2'd1, 1'b0, 1'b0);
        chk("R8 write ignored enable", 64'(rsp_target), 64'h10);
        req_valid = 1'b0;
        do_reset();
        issue(32'hB0000, 2'd1, 1'b0, 1'b0);
        chk("R12 register cleared", 64'(rsp_target), 64'h02);
        req_valid = 1'b0;
        @(negedge clk);
        chk("R1 idle", 64'(rsp_valid), 64'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule